// File: doc/BRIEF.md
# Four-Phase Video DAC Bus Serializer

This block packs one pixel and its timing flags into a four-beat group on a narrow bus that feeds an external video DAC. It is clocked at four times the pixel rate. In each group it sends the red component, then green, then blue, and in the fourth beat a word of inverted sync flags. A marker output stays high on the three colour beats and goes low on the sync beat, so the receiver can find where each group starts.

Each colour channel arrives 8 bits wide. Only the upper 7 bits reach the bus, which gives 21 bits of colour per pixel. The pixel, the enable and the sync flags are all sampled at the start of a group and held for its four beats. A low enable blanks the colour beats to black, and the sync beat keeps running. The block is placed between the pixel pipeline and the DAC pins. The pixel source must hold its outputs steady across the clock edge that starts each group.

Top module: `vdac_bus_serializer`

## Requirements
- R1: After reset is released, the marker repeats the pattern high, high, high, low, one beat per clock. Each group is exactly four clocks long.
- R2: Beat order is red, then green, then blue, then sync. Channel bit n+1 is driven onto bus line n.
- R3: The least significant bit of each 8-bit channel never reaches the bus. A channel value of 0x01 gives an all-zero colour beat.
- R4: In the sync beat, the flag input bits are: bit 0 composite, bit 1 horizontal, bit 2 clamp, bit 3 vertical, all active high. Bus line n carries the inverse of flag bit n for n = 0..3, and lines 4 to 6 are driven 0.
- R5: Pixel and flag inputs are sampled only on the clock that starts a group, which is the red beat. Input changes during the green, blue and sync beats do not change the remaining beats of that group.
- R6: While the active-low synchronous reset is asserted, the bus shows an idle sync word (lines 0 to 3 high, lines 4 to 6 low, value 0x0F) and the marker is low. The first clock after release starts a new group with its red beat.
- R7: When the enable sampled at the start of a group is low, all three colour beats of that group are 0. The sync beat still carries the inverted flags.
- R8: Enable is sampled at the start of a group only. Toggling it in the middle of a group does not blank or unblank that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_4x | input | 1 | Bus clock, four times the pixel rate |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel valid; low sends black for the group |
| pix_red | input | CHAN_W | Red channel |
| pix_grn | input | CHAN_W | Green channel |
| pix_blu | input | CHAN_W | Blue channel |
| sync_flags | input | SYNC_N | Active-high flags: composite, horizontal, clamp, vertical (bit 0 to 3) |
| dac_data | output | BUS_W | Multiplexed data bus to the DAC |
| dac_mark | output | 1 | Group marker: high on colour beats, low on the sync beat |

## Verification
The bench goes after group alignment. It uses walking single bits on each channel to expose a swapped or shifted line, which would move a set bit onto the wrong bus line. It checks that a channel value with only its lowest bit set gives a zero beat, which catches a design that drops the wrong bit. It changes inputs and enable in the middle of a group, which catches a design that samples on every beat: that design would mix two pixels in one group or blank only part of it. It asserts reset in the middle of a group, which catches a counter that fails to clear: after release, that design would start on a green or sync beat instead of red.

// File: rtl/vdac_pkg.sv
// Shared definitions for the video DAC bus serializer.
// Assumes a fixed four-beat group; only data widths are parameters.
package vdac_pkg;
    localparam int SLOTS = 4;
    localparam int PH_W  = $clog2(SLOTS);

    // Beat order within a group; the encoding is the beat index
    typedef enum logic [PH_W-1:0] {
        SLOT_RED = 2'd0,
        SLOT_GRN = 2'd1,
        SLOT_BLU = 2'd2,
        SLOT_SYN = 2'd3
    } slot_e;
endpackage

// File: rtl/vdac_phase_ctr.sv
// Beat counter: advances once per bus clock and wraps after the sync beat.
// Assumes the bus clock is four times the pixel rate.
module vdac_phase_ctr
    import vdac_pkg::*;
(
    input  logic  clk_4x,
    input  logic  rst_n,
    output slot_e phase_o
);
    slot_e phase_q;

    // Count beats; reset parks the counter on the red beat
    always_ff @(posedge clk_4x) begin
        if (!rst_n) phase_q <= SLOT_RED;
        else        phase_q <= slot_e'(phase_q + 1'b1);
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/vdac_capture.sv
// Holds green, blue and sync flags of the current group.
// Loads only at the start of a group, so a group never mixes two pixels.
// Colours are blanked here when enable is low at load time.
module vdac_capture #(
    parameter int CHAN_W = 8,
    parameter int SYNC_N = 4
) (
    input  logic              clk_4x,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              en_i,
    input  logic [CHAN_W-1:0] grn_i,
    input  logic [CHAN_W-1:0] blu_i,
    input  logic [SYNC_N-1:0] sync_i,
    output logic [CHAN_W-1:0] grn_o,
    output logic [CHAN_W-1:0] blu_o,
    output logic [SYNC_N-1:0] sync_o
);
    // Latch the pixel tail and flags at group start
    always_ff @(posedge clk_4x) begin
        if (!rst_n) begin
            grn_o  <= '0;
            blu_o  <= '0;
            sync_o <= '0;
        end else if (load_i) begin
            grn_o  <= en_i ? grn_i : '0;
            blu_o  <= en_i ? blu_i : '0;
            sync_o <= sync_i;
        end
    end
endmodule

// File: rtl/vdac_slot_mux.sv
// Selects the word for the current beat and registers it onto the bus.
// Red comes straight from the input on the group's first beat; later beats
// use captured values. Assumes CHAN_W >= BUS_W >= SYNC_N.
module vdac_slot_mux
    import vdac_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int BUS_W  = 7,
    parameter int SYNC_N = 4
) (
    input  logic              clk_4x,
    input  logic              rst_n,
    input  slot_e             phase_i,
    input  logic              en_i,
    input  logic [CHAN_W-1:0] red_i,
    input  logic [CHAN_W-1:0] grn_i,
    input  logic [CHAN_W-1:0] blu_i,
    input  logic [SYNC_N-1:0] sync_i,
    output logic [BUS_W-1:0]  data_o,
    output logic              mark_o
);
    localparam int TOP = CHAN_W - 1;

    logic [BUS_W-1:0] sync_word;
    logic [BUS_W-1:0] idle_word;
    logic [BUS_W-1:0] next_word;

    // Build the sync word: inverted flags on low lines, zero above
    for (genvar i = 0; i < BUS_W; i++) begin : g_sync_line
        if (i < SYNC_N) begin : g_flag
            assign sync_word[i] = ~sync_i[i];
            assign idle_word[i] = 1'b1;
        end else begin : g_spare
            assign sync_word[i] = 1'b0;
            assign idle_word[i] = 1'b0;
        end
    end

    // Pick the beat word; colours keep their upper BUS_W bits
    always_comb begin
        unique case (phase_i)
            SLOT_RED: next_word = en_i ? red_i[TOP -: BUS_W] : '0;
            SLOT_GRN: next_word = grn_i[TOP -: BUS_W];
            SLOT_BLU: next_word = blu_i[TOP -: BUS_W];
            default:  next_word = sync_word;
        endcase
    end

    // Register bus and marker; reset shows an idle sync beat
    always_ff @(posedge clk_4x) begin
        if (!rst_n) begin
            data_o <= idle_word;
            mark_o <= 1'b0;
        end else begin
            data_o <= next_word;
            mark_o <= (phase_i != SLOT_SYN);
        end
    end
endmodule

// File: rtl/vdac_bus_serializer.sv
// Top level: four-beat serializer from a parallel pixel to the DAC bus.
// Assumes the pixel source holds its inputs stable around group start.
module vdac_bus_serializer
    import vdac_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int BUS_W  = 7,
    parameter int SYNC_N = 4
) (
    input  logic              clk_4x,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic [CHAN_W-1:0] pix_red,
    input  logic [CHAN_W-1:0] pix_grn,
    input  logic [CHAN_W-1:0] pix_blu,
    input  logic [SYNC_N-1:0] sync_flags,
    output logic [BUS_W-1:0]  dac_data,
    output logic              dac_mark
);
    slot_e             phase_w;
    logic              load_w;
    logic [CHAN_W-1:0] cap_grn_w;
    logic [CHAN_W-1:0] cap_blu_w;
    logic [SYNC_N-1:0] cap_sync_w;

    assign load_w = (phase_w == SLOT_RED);

    vdac_phase_ctr u_phase (
        .clk_4x  (clk_4x),
        .rst_n   (rst_n),
        .phase_o (phase_w)
    );

    vdac_capture #(.CHAN_W(CHAN_W), .SYNC_N(SYNC_N)) u_cap (
        .clk_4x (clk_4x),
        .rst_n  (rst_n),
        .load_i (load_w),
        .en_i   (pix_en),
        .grn_i  (pix_grn),
        .blu_i  (pix_blu),
        .sync_i (sync_flags),
        .grn_o  (cap_grn_w),
        .blu_o  (cap_blu_w),
        .sync_o (cap_sync_w)
    );

    vdac_slot_mux #(.CHAN_W(CHAN_W), .BUS_W(BUS_W), .SYNC_N(SYNC_N)) u_mux (
        .clk_4x  (clk_4x),
        .rst_n   (rst_n),
        .phase_i (phase_w),
        .en_i    (pix_en),
        .red_i   (pix_red),
        .grn_i   (cap_grn_w),
        .blu_i   (cap_blu_w),
        .sync_i  (cap_sync_w),
        .data_o  (dac_data),
        .mark_o  (dac_mark)
    );
endmodule

// File: rtl/vdac_bus_serializer_chk.sv
// Property checker for the serializer, attached to the top by bind.
module vdac_bus_serializer_chk
    import vdac_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int BUS_W  = 7,
    parameter int SYNC_N = 4
) (
    input logic              clk_4x,
    input logic              rst_n,
    input logic              pix_en,
    input slot_e             phase_w,
    input logic [CHAN_W-1:0] cap_grn_w,
    input logic [SYNC_N-1:0] cap_sync_w,
    input logic [BUS_W-1:0]  dac_data,
    input logic              dac_mark
);
    // R1
    mark_after_sync_chk: assert property (@(posedge clk_4x) disable iff (!rst_n)
        !dac_mark |=> dac_mark);

    // R1
    mark_three_high_chk: assert property (@(posedge clk_4x) disable iff (!rst_n)
        (dac_mark && $past(dac_mark) && $past(dac_mark, 2)) |=> !dac_mark);

    // R2
    green_slot_chk: assert property (@(posedge clk_4x) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_w) == SLOT_GRN)
            |-> dac_data == $past(cap_grn_w[CHAN_W-1 -: BUS_W]));

    // R4
    sync_slot_chk: assert property (@(posedge clk_4x) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_w) == SLOT_SYN)
            |-> (dac_data[SYNC_N-1:0] == ~$past(cap_sync_w)
                 && dac_data[BUS_W-1:SYNC_N] == '0));

    // R5
    cap_hold_chk: assert property (@(posedge clk_4x) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_w) != SLOT_RED)
            |-> ($stable(cap_grn_w) && $stable(cap_sync_w)));

    // R7
    blank_red_chk: assert property (@(posedge clk_4x) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_w) == SLOT_RED && !$past(pix_en))
            |-> dac_data == '0);
endmodule

bind vdac_bus_serializer vdac_bus_serializer_chk #(
    .CHAN_W(CHAN_W), .BUS_W(BUS_W), .SYNC_N(SYNC_N)
) u_chk (
    .clk_4x     (clk_4x),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .phase_w    (phase_w),
    .cap_grn_w  (cap_grn_w),
    .cap_sync_w (cap_sync_w),
    .dac_data   (dac_data),
    .dac_mark   (dac_mark)
);

// File: tb/vdac_bus_serializer_tb_top.sv
// Self-checking bench: directed corners plus seeded random groups.
module vdac_bus_serializer_tb_top;
    logic       clk_4x = 1'b0;
    logic       rst_n  = 1'b0;
    logic       pix_en = 1'b0;
    logic [7:0] pix_red = '0, pix_grn = '0, pix_blu = '0;
    logic [3:0] sync_flags = '0;
    logic [6:0] dac_data;
    logic       dac_mark;

    int n_vec  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk_4x = ~clk_4x;

    vdac_bus_serializer dut_i (
        .clk_4x     (clk_4x),
        .rst_n      (rst_n),
        .pix_en     (pix_en),
        .pix_red    (pix_red),
        .pix_grn    (pix_grn),
        .pix_blu    (pix_blu),
        .sync_flags (sync_flags),
        .dac_data   (dac_data),
        .dac_mark   (dac_mark)
    );

    // Expected {mark, data} for beat k of a group
    function automatic logic [7:0] exp_beat(int k, logic [7:0] r, logic [7:0] g,
                                            logic [7:0] b, logic en, logic [3:0] s);
        case (k)
            0:       return {1'b1, en ? r[7:1] : 7'd0};
            1:       return {1'b1, en ? g[7:1] : 7'd0};
            2:       return {1'b1, en ? b[7:1] : 7'd0};
            default: return {1'b0, 3'b000, ~s};
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got mark/data %h, expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one pixel before its start edge and check all four beats.
    // When disturb is set, inputs are scrambled after the red beat.
    task automatic run_group(string req, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                             logic en, logic [3:0] s, bit disturb);
        pix_red = r; pix_grn = g; pix_blu = b; pix_en = en; sync_flags = s;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk_4x); #1;
            check(req, {dac_mark, dac_data}, exp_beat(k, r, g, b, en, s));
            if (disturb) begin
                #0.5;
                pix_red = 8'($urandom); pix_grn = 8'($urandom); pix_blu = 8'($urandom);
                pix_en = ~en; sync_flags = 4'($urandom);
            end
        end
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk_4x) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected fewer than 100000", cyc);
            report();
        end
    end

    initial begin
        void'($urandom(32'h0051_7e4d));
        repeat (3) @(posedge clk_4x);
        #1;
        // R6: idle sync word during reset
        check("R6 reset", {dac_mark, dac_data}, 8'h0F);
        @(negedge clk_4x);
        rst_n = 1'b1;
        // R6, R2: first group after release starts on red
        run_group("R6 R2 first group", 8'hAA, 8'h54, 8'hFE, 1'b1, 4'b0000, 0);
        // R2: walking bit, each channel
        for (int i = 1; i < 8; i++) begin
            run_group("R2 walk red", 8'(1 << i), 8'h00, 8'h00, 1'b1, 4'b0101, 0);
            run_group("R2 walk grn", 8'h00, 8'(1 << i), 8'h00, 1'b1, 4'b1010, 0);
            run_group("R2 walk blu", 8'h00, 8'h00, 8'(1 << i), 1'b1, 4'b0011, 0);
        end
        // R3: lowest bit dropped
        run_group("R3 lsb only", 8'h01, 8'h01, 8'h01, 1'b1, 4'b0000, 0);
        run_group("R3 all ones", 8'hFF, 8'hFE, 8'h7F, 1'b1, 4'b1111, 0);
        // R4: every flag combination
        for (int s = 0; s < 16; s++)
            run_group("R4 sync beat", 8'h80, 8'h40, 8'h20, 1'b1, 4'(s), 0);
        // R7: blanking keeps sync beat
        run_group("R7 blank", 8'hFF, 8'hFF, 8'hFF, 1'b0, 4'b1001, 0);
        // R5, R8: mid-group changes ignored
        run_group("R5 R8 hold en", 8'h3C, 8'hC3, 8'h66, 1'b1, 4'b0110, 1);
        run_group("R5 R8 hold blank", 8'h3C, 8'hC3, 8'h66, 1'b0, 4'b0110, 1);
        // R1: marker pattern over a short run
        for (int k = 0; k < 8; k++) begin
            @(posedge clk_4x); #1;
            check("R1 marker", {7'd0, dac_mark}, {7'd0, (k % 4) != 3});
        end
        // R6: reset in mid-group, then realigned restart
        @(posedge clk_4x); #2;
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk_4x); #1;
            check("R6 mid reset", {dac_mark, dac_data}, 8'h0F);
        end
        #1 rst_n = 1'b1;
        run_group("R6 restart", 8'h12, 8'h34, 8'h56, 1'b1, 4'b1100, 0);
        // Random groups
        for (int n = 0; n < 300; n++)
            run_group("R2 R5 R7 random", 8'($urandom), 8'($urandom), 8'($urandom),
                      1'($urandom_range(0, 3) != 0), 4'($urandom), bit'($urandom));
        done = 1;
        report();
    end
endmodule